// File: doc/BRIEF.md
# SPI Receive FIFO with Combined Level Interrupt

This block sits behind the serial shifter of an SPI port and buffers received words for the CPU. Each completed word is offered on a one-cycle strobe and lands in a 16-entry first-in first-out store. The CPU takes words through a pop strobe and sees each word on a registered read output in the following cycle. A fill count is always visible. Software can hold the pointers at zero with a clear bit, and reception restarts from empty when the bit drops.

One interrupt line reports three causes together: the fill count reaching a programmable trigger level, a receive error flagged by the shifter, and a sticky overflow flag. A word that completes while the store is full is discarded, and the overflow flag is set. A write-one strobe clears the flag. The trigger level resets to 31, which is above the depth, so the threshold cause stays silent until software lowers the level. While FIFO mode is off, the store is held empty and the line stays low, because the port's plain single-word interrupt path serves instead.

A small controller tracks the store with four named states. OFF means held by the clear bit or by FIFO mode being off. EMPTY, PARTIAL and FULL follow the fill count. The transitions are:
- hold: any state goes to OFF while the clear bit is set or FIFO mode is off.
- release: OFF goes to EMPTY, or to PARTIAL if a push comes in the same cycle.
- first word: EMPTY goes to PARTIAL on a push.
- fill up: PARTIAL goes to FULL on a push without a pop at count DEPTH-1.
- drain: PARTIAL goes to EMPTY on a pop without a push at count 1.
- make room: FULL goes to PARTIAL on a pop without a push.

Top module: `spi_rx_fifo_irq`

## Requirements
- R1: After reset the fill count is 0, the trigger level reads 31, the overflow flag is 0, the read output is 0 and the interrupt is low while no error is flagged.
- R2: Accepted words come out of the read output in the order they were pushed, one cycle after the pop strobe.
- R3: The fill count always equals the number of words held, from 0 to 16.
- R4: A push and a pop in the same cycle on a non-empty store leave the count unchanged. When the store is full this also sets no overflow.
- R5: A push while full without a pop discards the word, leaves the contents and count unchanged, and sets the overflow flag in the next cycle.
- R6: The overflow flag stays set until a write-one clear strobe. If a new overflow and a clear arrive in the same cycle, the flag stays set.
- R7: A pop on an empty store leaves the read output and the count unchanged. A push and a pop together on an empty store give a count of 1.
- R8: While the clear bit is 1, the count is forced to 0 and both pushes and pops are ignored. After release, the first word popped is the first word pushed after release.
- R9: The 5-bit trigger level is written by a load strobe and can be read back. The threshold cause is active exactly when the count is greater than or equal to the level.
- R10: With FIFO mode on, the interrupt is the OR of the threshold cause, the receive error input and the overflow flag.
- R11: With FIFO mode off, the store is held empty, pushes are ignored and the interrupt is low whatever its causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode on |
| fifo_clr | input | 1 | Hold pointers at zero while 1 |
| word_done | input | 1 | Shifter completed a word |
| word_in | input | WIDTH | Completed word |
| rd_en | input | 1 | CPU pop strobe |
| rd_data | output | WIDTH | Last word popped |
| fill_level | output | CNT_W | Words held |
| lvl_we | input | 1 | Trigger level load strobe |
| lvl_wdata | input | CNT_W | New trigger level |
| trig_level | output | CNT_W | Current trigger level |
| rx_err | input | 1 | Receive error from shifter |
| ovf_clr | input | 1 | Write-one clear of overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| rx_irq | output | 1 | Combined receive interrupt |

## Verification
The bench builds the block with DEPTH 16 and WIDTH 8, which keeps every fill count from 0 to 16 and every 5-bit trigger level from 0 to 31 within reach. The full cross of count and level is swept to check the threshold compare. Simultaneous push and pop is tried at every fill count, including full. The narrow data width lets each word carry a computed pattern, so the bench can follow the order of words through the store, overflow, clear and mode changes with a model kept in the bench.

// File: rtl/spirx_pkg.sv
package spirx_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } rxq_state_e;
endpackage

// File: rtl/spirx_store.sv
module spirx_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_clr,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            rdata  <= '0;
        end else if (do_clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rdata  <= mem[rd_ptr];
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> (cnt == '0));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_pop |=> $stable(rdata));
endmodule

// File: rtl/spirx_ctrl.sv
module spirx_ctrl
    import spirx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             fifo_clr,
    input  logic             word_done,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] cnt,
    output logic             do_clr,
    output logic             do_push,
    output logic             do_pop,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] NEAR_CNT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    rxq_state_e state, state_nx;
    logic hold;

    assign hold = !fifo_en || fifo_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (!hold) begin
                    state_nx = word_done ? ST_PART : ST_EMPTY;
                end
            end
            ST_EMPTY: begin
                if (hold) begin
                    state_nx = ST_OFF;
                end else if (word_done) begin
                    state_nx = ST_PART;
                end
            end
            ST_PART: begin
                if (hold) begin
                    state_nx = ST_OFF;
                end else if (word_done && !rd_en && cnt == NEAR_CNT) begin
                    state_nx = ST_FULL;
                end else if (rd_en && !word_done && cnt == ONE_CNT) begin
                    state_nx = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (hold) begin
                    state_nx = ST_OFF;
                end else if (rd_en && !word_done) begin
                    state_nx = ST_PART;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        do_clr  = hold;
        do_push = 1'b0;
        do_pop  = 1'b0;
        ovf_evt = 1'b0;
        unique case (state)
            ST_OFF, ST_EMPTY: begin
                do_push = !hold && word_done;
            end
            ST_PART: begin
                do_push = !hold && word_done;
                do_pop  = !hold && rd_en;
            end
            ST_FULL: begin
                do_pop  = !hold && rd_en;
                do_push = !hold && word_done && rd_en;
                ovf_evt = !hold && word_done && !rd_en;
            end
            default: ;
        endcase
    end

    // R5
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (cnt == FULL_CNT));

    // R7
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY || state == ST_OFF) |-> (cnt == '0));

    // R4
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && word_done && rd_en && !hold) |=> (cnt == FULL_CNT));
endmodule

// File: rtl/spirx_irq.sv
module spirx_irq #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             lvl_we,
    input  logic [CNT_W-1:0] lvl_wdata,
    input  logic             rx_err,
    input  logic             ovf_evt,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] lvl,
    output logic             ovf_flag,
    output logic             rx_irq
);
    logic thr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= '1;
        end else if (lvl_we) begin
            lvl <= lvl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_evt) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    assign thr_hit = (cnt >= lvl);
    assign rx_irq  = fifo_en && (thr_hit || rx_err || ovf_flag);

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R10
    ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $rose(ovf_flag)) |-> rx_irq);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !rx_irq);
endmodule

// File: rtl/spi_rx_fifo_irq.sv
module spi_rx_fifo_irq #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             fifo_clr,
    input  logic             word_done,
    input  logic [WIDTH-1:0] word_in,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] fill_level,
    input  logic             lvl_we,
    input  logic [CNT_W-1:0] lvl_wdata,
    output logic [CNT_W-1:0] trig_level,
    input  logic             rx_err,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    output logic             rx_irq
);
    logic do_clr, do_push, do_pop, ovf_evt;

    spirx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .word_done(word_done), .rd_en(rd_en), .cnt(fill_level),
        .do_clr(do_clr), .do_push(do_push), .do_pop(do_pop), .ovf_evt(ovf_evt)
    );

    spirx_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .do_clr(do_clr), .do_push(do_push),
        .do_pop(do_pop), .wdata(word_in), .rdata(rd_data), .cnt(fill_level)
    );

    spirx_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .cnt(fill_level),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .rx_err(rx_err),
        .ovf_evt(ovf_evt), .ovf_clr(ovf_clr), .lvl(trig_level),
        .ovf_flag(ovf_flag), .rx_irq(rx_irq)
    );
endmodule

// File: tb/tb_spi_rx_fifo_irq.sv
module tb_spi_rx_fifo_irq;
    localparam int CLK_P = 10;
    localparam int D     = 16;
    localparam int W     = 8;
    localparam int LW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1, fifo_clr = 1'b0, word_done = 1'b0, rd_en = 1'b0;
    logic lvl_we = 1'b0, rx_err = 1'b0, ovf_clr = 1'b0;
    logic [W-1:0]  word_in = '0;
    logic [LW-1:0] lvl_wdata = '0;
    logic [W-1:0]  rd_data;
    logic [LW-1:0] fill_level, trig_level;
    logic ovf_flag, rx_irq;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] last = '0;
    bit flag = 0;
    int lvl_m = 31;
    int seq = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_rx_fifo_irq #(.DEPTH(D), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .word_done(word_done), .word_in(word_in), .rd_en(rd_en),
        .rd_data(rd_data), .fill_level(fill_level), .lvl_we(lvl_we),
        .lvl_wdata(lvl_wdata), .trig_level(trig_level), .rx_err(rx_err),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .rx_irq(rx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        return fifo_en && ((q.size() >= lvl_m) || rx_err || flag);
    endfunction

    task automatic compare(input string tag);
        chk(fill_level == LW'(q.size()), {tag, " count"}, fill_level, q.size());
        chk(rd_data == last, {tag, " rd_data"}, rd_data, last);
        chk(ovf_flag == flag, {tag, " ovf"}, ovf_flag, flag);
        chk(rx_irq == exp_irq(), {tag, " irq"}, rx_irq, exp_irq());
    endtask

    function automatic logic [W-1:0] pat();
        seq++;
        return W'(seq * 37 + 11);
    endfunction

    task automatic cyc(input bit push, input bit pop, input bit clr,
                       input bit oclr, input string tag);
        logic [W-1:0] d;
        bit popv, pushok, hold, oset;
        d = pat();
        word_done = push; word_in = d; rd_en = pop;
        fifo_clr = clr; ovf_clr = oclr;
        @(negedge clk);
        word_done = 0; rd_en = 0; fifo_clr = 0; ovf_clr = 0;
        hold = !fifo_en || clr;
        oset = 0;
        if (hold) begin
            q.delete();
        end else begin
            popv   = pop && (q.size() > 0);
            pushok = push && ((q.size() < D) || popv);
            oset   = push && !pushok;
            if (popv) last = q.pop_front();
            if (pushok) q.push_back(d);
        end
        if (oset) flag = 1;
        else if (oclr) flag = 0;
        compare(tag);
    endtask

    task automatic wr_lvl(input int v);
        lvl_we = 1; lvl_wdata = LW'(v);
        @(negedge clk);
        lvl_we = 0;
        lvl_m = v;
        chk(trig_level == LW'(v), "R9 level readback", trig_level, v);
        chk(rx_irq == exp_irq(), "R9 threshold", rx_irq, exp_irq());
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(fill_level == 0, "R1 count", fill_level, 0);
        chk(trig_level == 5'd31, "R1 level", trig_level, 31);
        chk(ovf_flag == 0, "R1 ovf", ovf_flag, 0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        chk(rx_irq == 0, "R1 irq", rx_irq, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3: fill to full, then drain in order
        for (int i = 0; i < D; i++) cyc(1, 0, 0, 0, "R3 fill");
        // R5: overflow discards and sets flag
        cyc(1, 0, 0, 0, "R5 overflow");
        cyc(1, 0, 0, 0, "R5 overflow again");
        // R10: flag drives interrupt
        chk(rx_irq == 1, "R10 ovf cause", rx_irq, 1);
        // R6: clear, then set wins over clear
        cyc(0, 0, 0, 1, "R6 clear");
        cyc(1, 0, 0, 1, "R6 set wins");
        cyc(0, 0, 0, 0, "R6 sticky");
        cyc(0, 0, 0, 1, "R6 clear again");
        for (int i = 0; i < D; i++) cyc(0, 1, 0, 0, "R2 drain order");
        // R7: pop on empty
        cyc(0, 1, 0, 0, "R7 empty pop");
        cyc(0, 1, 0, 0, "R7 empty pop repeat");
        cyc(1, 1, 0, 0, "R7 push pop on empty");
        cyc(0, 1, 0, 0, "R7 drain");

        // R4: swap at every count including full
        for (int k = 1; k <= D; k++) begin
            cyc(0, 0, 1, 0, "R8 clear");
            for (int i = 0; i < k; i++) cyc(1, 0, 0, 0, "R4 fill");
            cyc(1, 1, 0, 0, "R4 swap");
            cyc(1, 1, 0, 0, "R4 swap again");
            cyc(0, 1, 0, 0, "R4 order");
        end

        // R8: clear held ignores push and pop
        cyc(0, 0, 1, 0, "R8 clear");
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R8 prefill");
        cyc(1, 1, 1, 0, "R8 held");
        cyc(1, 0, 1, 0, "R8 held push");
        cyc(0, 1, 1, 0, "R8 held pop");
        cyc(1, 0, 0, 0, "R8 restart push");
        cyc(1, 0, 0, 0, "R8 restart push2");
        cyc(0, 1, 0, 0, "R8 restart first word");
        cyc(0, 1, 0, 0, "R8 restart second word");

        // R9: full sweep of count against level
        for (int n = 0; n <= D; n++) begin
            cyc(0, 0, 1, 0, "R8 clear");
            for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, "R3 sweep fill");
            for (int l = 0; l < 32; l++) wr_lvl(l);
        end
        wr_lvl(31);

        // R10: error cause alone
        cyc(0, 0, 1, 0, "R8 clear");
        rx_err = 1;
        cyc(0, 0, 0, 0, "R10 error cause");
        rx_err = 0;
        cyc(0, 0, 0, 0, "R10 error gone");

        // R11: mode off holds empty and silences interrupt
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R11 prefill");
        fifo_en = 0;
        rx_err = 1;
        cyc(1, 0, 0, 0, "R11 off push");
        cyc(1, 1, 0, 0, "R11 off pop");
        chk(rx_irq == 0, "R11 quiet", rx_irq, 0);
        rx_err = 0;
        fifo_en = 1;
        cyc(1, 0, 0, 0, "R11 back on");
        cyc(0, 1, 0, 0, "R11 back on read");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule